// File: doc/BRIEF.md
# CAN Transmit Driver Enable Controller

This block is the digital supervisor inside a high-speed CAN line transceiver. It decides, cycle by cycle, whether the differential output stage may drive the bus and whether it must be held fully in high impedance. The serial transmit stream from the protocol controller passes through a synchroniser. A low (dominant) level turns the drivers on and a high (recessive) level turns them off.

Three mechanisms can veto the drive. A stuck-dominant watchdog cuts the drivers once the transmit line has been low for a parameterised number of clock cycles, and it re-arms only after the line returns high. A power-up gate keeps the outputs in high impedance until the supply comparator reports the upper threshold. If the transmit line is low at that moment, the gate waits until the line goes high. A brown-out lockout forces high impedance as soon as the supply drops under the lower threshold and holds it until the upper threshold is seen again.

A two-bit mode select picks high-speed, slope-controlled or standby operation. Only standby affects the driver logic: it switches the transmitter off and flags the receiver as running in reduced power. The received bus state is always passed straight through.

Top module: `can_drv_enable`

## Requirements
- R1: With the block powered and not in standby, `drvEnable` is 1 exactly while the synchronised `txdIn` is 0. The input takes two clock edges to reach the output, and `txdIn`=1 gives `drvEnable`=0.
- R2: While `txdIn` is held low continuously, `drvEnable` is 1 for exactly `TIMEOUT_CYC` cycles and then goes to 0. The counter saturates and does not wrap.
- R3: After the timeout, `drvEnable` stays 0 for as long as `txdIn` stays low.
- R4: Returning `txdIn` high clears the timeout. The next dominant period again gets a full window of `TIMEOUT_CYC` cycles.
- R5: After reset, `drvHiZ`=1 and `drvEnable`=0 until `supplyAboveHigh` is seen at 1 together with `txdIn` high.
- R6: If `txdIn` is low when `supplyAboveHigh` first asserts, `drvHiZ` stays 1 and `drvEnable` stays 0 until `txdIn` has gone high.
- R7: `supplyBelowLow`=1 makes `drvHiZ`=1 and `drvEnable`=0 one clock edge later. It takes priority over `supplyAboveHigh`.
- R8: After a brown-out, `drvHiZ` stays 1 while `supplyAboveHigh` is 0, even once `supplyBelowLow` has returned to 0.
- R9: `modeSel` 2'b10 or 2'b11 (standby) forces `drvEnable`=0 and `rxLowPower`=1 in the same cycle. `drvHiZ` is left to the power state.
- R10: `modeSel` 2'b00 (high-speed) and 2'b01 (slope control) give identical driver behaviour with `rxLowPower`=0.
- R11: `rxdOut` equals `busRxIn` in every mode and power state, including high impedance and standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| txdIn | input | 1 | Serial transmit data from protocol controller (0 = dominant) |
| modeSel | input | 2 | 00 high-speed, 01 slope control, 1x standby |
| supplyAboveHigh | input | 1 | Supply above power-on upper threshold |
| supplyBelowLow | input | 1 | Supply below power-on lower threshold |
| busRxIn | input | 1 | Digitised bus state from receive comparator |
| drvEnable | output | 1 | Turn on the bus output drivers |
| drvHiZ | output | 1 | Hold bus pins in high impedance |
| rxLowPower | output | 1 | Receiver in reduced-power operation |
| rxdOut | output | 1 | Received bus state to protocol controller |

## Verification
The hardest situation to reach is the supply turning valid while the transmit line is already dominant. It must be entered from a fresh power-down with the line held low, and the low time must stay well inside the timeout window so that the watchdog does not mask the effect. The stimulus table does this first: it drops `txdIn` while the supply is still invalid, then raises `supplyAboveHigh`, and only later releases the line. The bench overrides the timeout to a short value so that a full saturated dominant run, its release and a second run fit in a directed test. In that test, counting the cycles with the drivers on pins the window length exactly.

// File: rtl/can_drv_pkg.sv
package can_drv_pkg;

  // Operating mode encoding on modeSel
  typedef enum logic [1:0] {
    MODE_FAST     = 2'b00,
    MODE_SLOPE    = 2'b01,
    MODE_STBY     = 2'b10,
    MODE_STBY_ALT = 2'b11
  } modeSel_e;

  // Supply gating state
  typedef enum logic [1:0] {
    PWR_OFF      = 2'b00,
    PWR_WAIT_REC = 2'b01,
    PWR_ON       = 2'b10
  } pwrState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic txArmed;  // transmitter may drive when data is dominant
    logic hiZ;      // pins held in high impedance
  } ctrlStrobe_t;

endpackage

// File: rtl/can_drv_datapath.sv
module can_drv_datapath
  import can_drv_pkg::*;
#(
  parameter int TIMEOUT_CYC = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        txdIn,
  input  ctrlStrobe_t strobe,
  output logic        txdLevel,
  output logic        drvEnable
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_CYC);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [CNT_W-1:0]       domCnt;
  logic                   timedOut;

  // Synchroniser chain, reset to recessive
  always_ff @(posedge clk) begin
    if (rst) begin
      syncReg <= '1;
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], txdIn};
    end
  end

  assign txdLevel = syncReg[SYNC_STAGES-1];

  // Dominant duration counter: cleared by recessive, saturates at limit
  always_ff @(posedge clk) begin
    if (rst) begin
      domCnt <= '0;
    end else if (txdLevel) begin
      domCnt <= '0;
    end else if (domCnt != CNT_MAX) begin
      domCnt <= domCnt + 1'b1;
    end
  end

  assign timedOut  = (domCnt == CNT_MAX);
  assign drvEnable = strobe.txArmed & ~txdLevel & ~timedOut;

endmodule

// File: rtl/can_drv_ctrl.sv
module can_drv_ctrl
  import can_drv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  modeSel,
  input  logic        supplyAboveHigh,
  input  logic        supplyBelowLow,
  input  logic        txdLevel,
  output ctrlStrobe_t strobe,
  output logic        rxLowPower
);

  pwrState_e pwrState, pwrNext;
  logic      standby;

  assign standby = (modeSel == MODE_STBY) || (modeSel == MODE_STBY_ALT);

  always_comb begin
    pwrNext = pwrState;
    if (supplyBelowLow) begin
      pwrNext = PWR_OFF;
    end else begin
      case (pwrState)
        PWR_OFF: begin
          if (supplyAboveHigh) pwrNext = txdLevel ? PWR_ON : PWR_WAIT_REC;
        end
        PWR_WAIT_REC: begin
          if (txdLevel) pwrNext = PWR_ON;
        end
        PWR_ON:  pwrNext = PWR_ON;
        default: pwrNext = PWR_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwrState <= PWR_OFF;
    else     pwrState <= pwrNext;
  end

  assign strobe.txArmed = (pwrState == PWR_ON) & ~standby;
  assign strobe.hiZ     = (pwrState != PWR_ON);
  assign rxLowPower     = standby;

endmodule

// File: rtl/can_drv_enable.sv
module can_drv_enable
  import can_drv_pkg::*;
#(
  parameter int TIMEOUT_CYC = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txdIn,
  input  logic [1:0] modeSel,
  input  logic       supplyAboveHigh,
  input  logic       supplyBelowLow,
  input  logic       busRxIn,
  output logic       drvEnable,
  output logic       drvHiZ,
  output logic       rxLowPower,
  output logic       rxdOut
);

  ctrlStrobe_t strobe;
  logic        txdLevel;

  can_drv_ctrl u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .modeSel         (modeSel),
    .supplyAboveHigh (supplyAboveHigh),
    .supplyBelowLow  (supplyBelowLow),
    .txdLevel        (txdLevel),
    .strobe          (strobe),
    .rxLowPower      (rxLowPower)
  );

  can_drv_datapath #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .txdIn     (txdIn),
    .strobe    (strobe),
    .txdLevel  (txdLevel),
    .drvEnable (drvEnable)
  );

  assign drvHiZ = strobe.hiZ;
  assign rxdOut = busRxIn;

endmodule

// File: rtl/can_drv_checker.sv
module can_drv_checker #(
  parameter int TIMEOUT_CYC = 250000,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       txdIn,
  input logic [1:0] modeSel,
  input logic       supplyAboveHigh,
  input logic       supplyBelowLow,
  input logic       busRxIn,
  input logic       drvEnable,
  input logic       drvHiZ,
  input logic       rxLowPower,
  input logic       rxdOut
);

  localparam int RUN_W = $clog2(TIMEOUT_CYC + 2);

  logic [1:0]       age;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // Consecutive cycles with drivers on, before the current one
  always_ff @(posedge clk) begin
    if (rst || !drvEnable)            runLen <= '0;
    else if (runLen != '1)            runLen <= runLen + 1'b1;
  end

  // R1: drivers only on when the data seen two edges back was dominant
  a_r1_dominant_only: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && drvEnable) |-> !$past(txdIn, 2));

  // R2: no dominant run of the drivers exceeds the timeout window
  a_r2_window_limit: assert property (@(posedge clk) disable iff (rst)
    drvEnable |-> (runLen < RUN_W'(TIMEOUT_CYC)));

  // R7: a brown-out seen at one edge leaves the pins in high impedance
  a_r7_brownout_hiz: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && $past(supplyBelowLow)) |-> (drvHiZ && !drvEnable));

  // R8: leaving high impedance never happens while the supply is low
  a_r8_leave_hiz: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && $fell(drvHiZ)) |-> !$past(supplyBelowLow));

  // R9: standby keeps the transmitter off and flags low-power receive
  a_r9_standby_off: assert property (@(posedge clk) disable iff (rst)
    modeSel[1] |-> (!drvEnable && rxLowPower));

  // R11: received data follows the bus
  a_r11_rxd_pass: assert property (@(posedge clk) disable iff (rst)
    rxdOut == busRxIn);

  // R5/R7: drive and high impedance are exclusive
  a_r5_hiz_no_drive: assert property (@(posedge clk) disable iff (rst)
    drvHiZ |-> !drvEnable);

  logic unusedIn;
  assign unusedIn = supplyAboveHigh;

endmodule

bind can_drv_enable can_drv_checker #(
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/test_can_drv_enable.sv
module test_can_drv_enable;

  localparam int T = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txdIn = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic       supplyAboveHigh = 1'b0;
  logic       supplyBelowLow = 1'b0;
  logic       busRxIn = 1'b1;
  logic       drvEnable, drvHiZ, rxLowPower, rxdOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_drv_enable #(.TIMEOUT_CYC(T)) i_can_drv_enable (
    .clk, .rst, .txdIn, .modeSel, .supplyAboveHigh, .supplyBelowLow,
    .busRxIn, .drvEnable, .drvHiZ, .rxLowPower, .rxdOut
  );

  typedef struct packed {
    logic       ph;
    logic       pl;
    logic [1:0] mode;
    logic       txd;
    logic       bus;
    logic       eDrv;
    logic       eHiZ;
    logic       eLp;
    logic       eRxd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'b00,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1}, // R5 unpowered
    '{1'b0,1'b0,2'b00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0}, // R5 dominant, no supply
    '{1'b1,1'b0,2'b00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0}, // R6 valid while dominant
    '{1'b1,1'b0,2'b00,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1}, // R6 release -> powered
    '{1'b1,1'b0,2'b00,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R1 dominant drives
    '{1'b1,1'b0,2'b00,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1}, // R1 recessive off
    '{1'b1,1'b0,2'b01,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R10 slope mode drives
    '{1'b1,1'b0,2'b10,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0}, // R9 standby
    '{1'b1,1'b0,2'b11,1'b1,1'b1, 1'b0,1'b0,1'b1,1'b1}, // R9 alt standby, R11
    '{1'b1,1'b1,2'b00,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0}, // R7 priority
    '{1'b0,1'b0,2'b00,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b1}, // R8 hysteresis, R11
    '{1'b1,1'b0,2'b00,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0}  // R8 recovery
  };

  task automatic stepCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hiCnt;
    // Reset with supply valid: reset dominates
    supplyAboveHigh = 1'b1;
    stepCyc(3);
    check("R5 hiz in reset", drvHiZ, 1);
    check("R5 drv in reset", drvEnable, 0);
    supplyAboveHigh = 1'b0;
    rst = 1'b0;
    stepCyc(2);
    check("R5 hiz after reset", drvHiZ, 1);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      supplyAboveHigh = VECS[v].ph;
      supplyBelowLow  = VECS[v].pl;
      modeSel         = VECS[v].mode;
      txdIn           = VECS[v].txd;
      busRxIn         = VECS[v].bus;
      stepCyc(4);
      check($sformatf("R1/R5-R11 vec%0d drvEnable", v), drvEnable, VECS[v].eDrv);
      check($sformatf("R5-R8 vec%0d drvHiZ", v), drvHiZ, VECS[v].eHiZ);
      check($sformatf("R9/R10 vec%0d rxLowPower", v), rxLowPower, VECS[v].eLp);
      check($sformatf("R11 vec%0d rxdOut", v), rxdOut, VECS[v].eRxd);
    end

    // R2/R3: timeout window length with powered, high-speed mode
    busRxIn = 1'b1;
    txdIn = 1'b1;
    stepCyc(4);
    txdIn = 1'b0;
    hiCnt = 0;
    for (int i = 0; i < 2 * T; i++) begin
      stepCyc(1);
      if (drvEnable) hiCnt++;
    end
    check("R2 dominant window length", hiCnt, T);
    check("R3 stays off while dominant", drvEnable, 0);

    // R4: release and re-arm
    txdIn = 1'b1;
    stepCyc(4);
    check("R4 recessive after timeout", drvEnable, 0);
    txdIn = 1'b0;
    hiCnt = 0;
    for (int i = 0; i < 2 * T; i++) begin
      stepCyc(1);
      if (drvEnable) hiCnt++;
    end
    check("R4 fresh window length", hiCnt, T);

    // R7: brown-out in the middle of a dominant bit
    txdIn = 1'b1;
    stepCyc(4);
    txdIn = 1'b0;
    stepCyc(4);
    check("R7 driving before brown-out", drvEnable, 1);
    supplyBelowLow = 1'b1;
    stepCyc(1);
    check("R7 hiz one edge after brown-out", drvHiZ, 1);
    check("R7 drv off one edge after brown-out", drvEnable, 0);

    // R8: hysteresis, then recovery
    supplyBelowLow = 1'b0;
    supplyAboveHigh = 1'b0;
    txdIn = 1'b1;
    stepCyc(6);
    check("R8 hiz held between thresholds", drvHiZ, 1);
    supplyAboveHigh = 1'b1;
    stepCyc(2);
    check("R8 powered after upper threshold", drvHiZ, 0);
    txdIn = 1'b0;
    stepCyc(3);
    check("R1 drive after recovery", drvEnable, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule